// File: doc/BRIEF.md
# Single-Precision Exponent Extraction Lane

This combinational lane takes one IEEE-754 single-precision operand and returns floor(log2(|x|)) as an exactly encoded single-precision value. Normal operands yield their unbiased exponent. Subnormal operands are normalized by a leading-zero count on the fraction. Zero, infinity and NaN each map to a fixed class of result.

A denormals-are-zero control input makes any operand with a zero exponent field behave as zero. Two per-lane flags are produced for the surrounding datapath: one for an invalid operation and one for a subnormal operand. The lane has no state. It is meant to be replicated across the elements of a wider vector unit, with masking and operand delivery handled outside it.

Top module: `fexp_lane`

## Requirements
- R1: The operand sign bit (bit 31) has no effect on the result or the flags for any operand that is not a NaN.
- R2: For an operand with exponent field E in 1..254, the result is the single-precision encoding of the integer E-127. Examples: 0x40000000 (2.0) gives 0x3F800000, and 0x00800000 gives 0xC2FC0000 (-126.0).
- R3: A NaN operand (exponent field 255, fraction nonzero) returns the same word with fraction bit 22 forced to 1. The sign bit and fraction bits 21..0 are kept.
- R4: The invalid flag is 1 exactly when the operand is a signaling NaN, meaning exponent field 255, fraction nonzero and fraction bit 22 equal to 0. For every other operand the flag is 0.
- R5: An infinite operand of either sign (exponent field 255, fraction zero) returns 0x7F800000.
- R6: An operand with exponent field 0 and fraction 0 returns 0xFF800000, whatever the value of daz_i.
- R7: With daz_i = 1, an operand with exponent field 0 and a nonzero fraction returns 0xFF800000, and the subnormal flag stays 0.
- R8: With daz_i = 0, an operand with exponent field 0 and a nonzero fraction returns the encoding of -127-L, where L is the number of leading zeros in the 23-bit fraction. This covers the range -127 to -149.
- R9: An operand with exponent field 127 returns +0.0 (0x00000000).
- R10: The subnormal flag is 1 exactly when the exponent field is 0, the fraction is nonzero and daz_i = 0. For every other operand it is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_i | input | 32 | Single-precision operand |
| daz_i | input | 1 | Treat subnormal operands as zero |
| res_o | output | 32 | Single-precision exponent result |
| flag_inv_o | output | 1 | Invalid-operation flag (signaling NaN operand) |
| flag_den_o | output | 1 | Subnormal-operand flag |

## Verification
The bench sweeps all 256 exponent field values. Each is paired with a set of fraction patterns: zero, every single set bit, all ones, and a few mixed words. Each combination is tried with both signs and both daz_i settings. The single-bit fractions push the subnormal leading-zero count through every value from 0 to 22. The exponent sweep reaches every integer from -126 to +127 through the integer-to-float path. The sign and daz_i pairs separate operand classes whose results must match from those that must differ. The mixed fractions separate quiet from signaling NaNs.

// File: rtl/fexp_pkg.sv
package fexp_pkg;

  // Operand classes resolved before the result is selected
  typedef enum logic [2:0] {
    CLS_ZERO   = 3'd0,
    CLS_SUBN   = 3'd1,
    CLS_NORMAL = 3'd2,
    CLS_INF    = 3'd3,
    CLS_QNAN   = 3'd4,
    CLS_SNAN   = 3'd5
  } op_class_e;

endpackage

// File: rtl/fexp_classify.sv
module fexp_classify
  import fexp_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input  logic [EXP_W-1:0]  exp_f,
  input  logic [FRAC_W-1:0] frac_f,
  input  logic              daz,
  output op_class_e         cls
);

  logic exp_all_ones;
  logic exp_all_zero;
  logic frac_nz;

  assign exp_all_ones = &exp_f;
  assign exp_all_zero = ~|exp_f;
  assign frac_nz      = |frac_f;

  always_comb begin
    if (exp_all_ones) begin
      if (!frac_nz)                cls = CLS_INF;
      else if (frac_f[FRAC_W-1])   cls = CLS_QNAN;
      else                         cls = CLS_SNAN;
    end else if (exp_all_zero) begin
      if (frac_nz && !daz)         cls = CLS_SUBN;
      else                         cls = CLS_ZERO;
    end else begin
      cls = CLS_NORMAL;
    end
  end

endmodule

// File: rtl/fexp_lzc.sv
module fexp_lzc #(
  parameter int W  = 23,
  localparam int CW = $clog2(W + 1)
) (
  input  logic [W-1:0]  vec,
  output logic [CW-1:0] cnt,
  output logic          all_zero
);

  // Priority encoder: the highest set bit wins, so scan upward and let
  // later hits override earlier ones.
  always_comb begin
    cnt = CW'(W);
    for (int i = 0; i < W; i++) begin
      if (vec[i]) cnt = CW'(W - 1 - i);
    end
  end

  assign all_zero = ~|vec;

endmodule

// File: rtl/fexp_i2f.sv
module fexp_i2f #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  parameter int INT_W  = 10,
  localparam int WORD_W = 1 + EXP_W + FRAC_W,
  localparam int BIAS   = (1 << (EXP_W - 1)) - 1,
  localparam int CW     = $clog2(INT_W + 1)
) (
  input  logic signed [INT_W-1:0] val,
  output logic [WORD_W-1:0]       flt
);

  logic             neg;
  logic [INT_W-1:0] mag;
  logic [CW-1:0]    lz;
  logic             mag_zero;
  logic [INT_W-1:0] aligned;
  logic [EXP_W-1:0] exp_f;
  logic [FRAC_W-1:0] frac_f;

  assign neg = val[INT_W-1];
  assign mag = neg ? INT_W'(-val) : INT_W'(val);

  fexp_lzc #(.W(INT_W)) i_mag_lzc (
    .vec      (mag),
    .cnt      (lz),
    .all_zero (mag_zero)
  );

  // Shift past the leading one; what remains is the stored fraction.
  // The magnitude is narrower than the fraction, so nothing is rounded.
  assign aligned = mag << (lz + CW'(1));
  assign exp_f   = EXP_W'(BIAS + INT_W - 1) - EXP_W'(lz);

  generate
    if (FRAC_W > INT_W) begin : g_pad
      assign frac_f = {aligned, {(FRAC_W - INT_W){1'b0}}};
    end else begin : g_cut
      assign frac_f = aligned[INT_W-1 -: FRAC_W];
    end
  endgenerate

  assign flt = mag_zero ? '0 : {neg, exp_f, frac_f};

endmodule

// File: rtl/fexp_lane.sv
module fexp_lane
  import fexp_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  localparam int WORD_W = 1 + EXP_W + FRAC_W,
  localparam int INT_W  = EXP_W + 2,
  localparam int BIAS   = (1 << (EXP_W - 1)) - 1,
  localparam int LZ_W   = $clog2(FRAC_W + 1)
) (
  input  logic [WORD_W-1:0] op_i,
  input  logic              daz_i,
  output logic [WORD_W-1:0] res_o,
  output logic              flag_inv_o,
  output logic              flag_den_o
);

  localparam logic [WORD_W-1:0] POS_INF = {1'b0, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
  localparam logic [WORD_W-1:0] NEG_INF = {1'b1, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};

  logic               op_sign;
  logic [EXP_W-1:0]   op_exp;
  logic [FRAC_W-1:0]  op_frac;
  op_class_e          cls;
  logic [LZ_W-1:0]    frac_lz;
  logic               frac_zero;
  logic signed [INT_W-1:0] int_exp;
  logic [WORD_W-1:0]  conv;

  assign op_sign = op_i[WORD_W-1];
  assign op_exp  = op_i[FRAC_W +: EXP_W];
  assign op_frac = op_i[FRAC_W-1:0];

  fexp_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) i_classify (
    .exp_f  (op_exp),
    .frac_f (op_frac),
    .daz    (daz_i),
    .cls    (cls)
  );

  fexp_lzc #(.W(FRAC_W)) i_frac_lzc (
    .vec      (op_frac),
    .cnt      (frac_lz),
    .all_zero (frac_zero)
  );

  // Signed integer exponent. A subnormal with its top fraction bit set
  // sits one step below the smallest normal exponent.
  always_comb begin
    case (cls)
      CLS_NORMAL: int_exp = $signed(INT_W'(op_exp)) - $signed(INT_W'(BIAS));
      CLS_SUBN:   int_exp = -$signed(INT_W'(BIAS)) - $signed(INT_W'(frac_lz));
      default:    int_exp = '0;
    endcase
  end

  fexp_i2f #(.EXP_W(EXP_W), .FRAC_W(FRAC_W), .INT_W(INT_W)) i_i2f (
    .val (int_exp),
    .flt (conv)
  );

  always_comb begin
    case (cls)
      CLS_INF:             res_o = POS_INF;
      CLS_ZERO:            res_o = NEG_INF;
      CLS_QNAN, CLS_SNAN:  res_o = {op_sign, op_exp, 1'b1, op_frac[FRAC_W-2:0]};
      default:             res_o = conv;
    endcase
  end

  assign flag_inv_o = (cls == CLS_SNAN);
  assign flag_den_o = (cls == CLS_SUBN) && !frac_zero;

endmodule

// File: rtl/fexp_lane_chk.sv
module fexp_lane_chk #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  localparam int WORD_W = 1 + EXP_W + FRAC_W,
  localparam int BIAS   = (1 << (EXP_W - 1)) - 1
) (
  input logic [WORD_W-1:0] op_i,
  input logic              daz_i,
  input logic [WORD_W-1:0] res_o,
  input logic              flag_inv_o,
  input logic              flag_den_o
);

  logic [EXP_W-1:0]  c_exp;
  logic [FRAC_W-1:0] c_frac;
  logic [EXP_W-1:0]  r_exp;

  assign c_exp  = op_i[FRAC_W +: EXP_W];
  assign c_frac = op_i[FRAC_W-1:0];
  assign r_exp  = res_o[FRAC_W +: EXP_W];

  always_comb begin
    if (&c_exp && c_frac == '0)
      AST_INF_POSITIVE: assert (res_o == {1'b0, {EXP_W{1'b1}}, {FRAC_W{1'b0}}}); // R5
    if (c_exp == '0 && (c_frac == '0 || daz_i))
      AST_ZERO_NEG_INF: assert (res_o == {1'b1, {EXP_W{1'b1}}, {FRAC_W{1'b0}}}); // R6
    if (&c_exp && c_frac != '0)
      AST_NAN_QUIETED: assert (res_o[FRAC_W-1] && &r_exp && res_o[FRAC_W-2:0] == c_frac[FRAC_W-2:0]); // R3
    if (flag_inv_o)
      AST_INV_ON_NAN: assert (&r_exp && &c_exp && !c_frac[FRAC_W-1]); // R4
    if (flag_den_o)
      AST_DEN_ON_SUBN: assert (c_exp == '0 && !daz_i && !(&r_exp)); // R10
    if (c_exp == EXP_W'(BIAS))
      AST_UNIT_ZERO: assert (res_o == '0); // R9
    if (c_exp != '0 && !(&c_exp) && c_exp != EXP_W'(BIAS))
      AST_NORMAL_SIGN: assert (res_o[WORD_W-1] == (c_exp < EXP_W'(BIAS))); // R2
  end

endmodule

bind fexp_lane fexp_lane_chk #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) i_fexp_lane_chk (
  .op_i       (op_i),
  .daz_i      (daz_i),
  .res_o      (res_o),
  .flag_inv_o (flag_inv_o),
  .flag_den_o (flag_den_o)
);

// File: tb/test_fexp_lane.sv
`timescale 1ns/1ps
module test_fexp_lane;

  logic        clk;
  logic        rst_n;
  logic [31:0] op_i;
  logic        daz_i;
  logic [31:0] res_o;
  logic        flag_inv_o;
  logic        flag_den_o;

  int n_checks;
  int n_fail;

  fexp_lane i_fexp_lane (
    .op_i       (op_i),
    .daz_i      (daz_i),
    .res_o      (res_o),
    .flag_inv_o (flag_inv_o),
    .flag_den_o (flag_den_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp_v);
    n_checks++;
    if (got !== exp_v) begin
      n_fail++;
      $display("FAIL %s op=%h daz=%0d got=%h exp=%h", req, op_i, daz_i, got, exp_v);
    end
  endtask

  // Exact integer to single-precision encoding, by arithmetic
  function automatic logic [31:0] int_to_sp(input int v);
    int m;
    int p;
    int fr;
    if (v == 0) return 32'h0;
    m = (v < 0) ? -v : v;
    p = 0;
    while ((1 << (p + 1)) <= m) p++;
    fr = (m - (1 << p)) << (23 - p);
    return {(v < 0), 8'(p + 127), 23'(fr)};
  endfunction

  function automatic int top_bit(input logic [22:0] f);
    int p;
    p = 0;
    while (p < 22 && (32'(f) >= (32'd1 << (p + 1)))) p++;
    return p;
  endfunction

  task automatic apply(input logic [31:0] op, input logic daz);
    @(posedge clk);
    op_i  = op;
    daz_i = daz;
    @(negedge clk);
  endtask

  // Check one operand against its class rule
  task automatic check_one(input logic [31:0] op, input logic daz);
    logic [7:0]  e;
    logic [22:0] f;
    apply(op, daz);
    e = op[30:23];
    f = op[22:0];
    if (e == 8'hFF && f == 0) begin
      check("R5", res_o, 32'h7F800000);
      check("R4", {31'b0, flag_inv_o}, 32'd0);
    end else if (e == 8'hFF) begin
      check("R3", res_o, {op[31], 8'hFF, 1'b1, f[21:0]});
      check("R4", {31'b0, flag_inv_o}, {31'b0, !f[22]});
    end else if (e == 0 && f == 0) begin
      check("R6", res_o, 32'hFF800000);
    end else if (e == 0 && daz) begin
      check("R7", res_o, 32'hFF800000);
      check("R7", {31'b0, flag_den_o}, 32'd0);
    end else if (e == 0) begin
      check("R8", res_o, int_to_sp(-127 - (22 - top_bit(f))));
    end else if (e == 8'd127) begin
      check("R9", res_o, 32'h0);
    end else begin
      check("R2", res_o, int_to_sp(int'(e) - 127));
    end
    check("R10", {31'b0, flag_den_o}, {31'b0, (e == 0 && f != 0 && !daz)});
    if (e != 8'hFF) check("R4", {31'b0, flag_inv_o}, 32'd0);
  endtask

  initial begin
    logic [31:0] pos_res;
    logic [1:0]  pos_flags;
    logic [22:0] fr;
    n_checks = 0;
    n_fail   = 0;
    rst_n    = 1'b0;
    op_i     = 32'h0;
    daz_i    = 1'b0;
    repeat (2) @(posedge clk);
    rst_n = 1'b1;

    // Idle state after reset: +0.0 operand
    @(negedge clk);
    check("R6", res_o, 32'hFF800000);

    // Directed values
    check_one(32'h40000000, 1'b0);
    check("R2", res_o, 32'h3F800000);
    check_one(32'h3F800000, 1'b0);
    check("R9", res_o, 32'h00000000);
    check_one(32'h00800000, 1'b0);
    check("R2", res_o, 32'hC2FC0000);
    check_one(32'h00000001, 1'b0);
    check("R8", res_o, int_to_sp(-149));
    check_one(32'h00400000, 1'b0);
    check("R8", res_o, int_to_sp(-127));
    check_one(32'h7F800001, 1'b0);
    check("R4", {31'b0, flag_inv_o}, 32'd1);

    // Sweep: every exponent, many fractions, both signs, both daz settings
    for (int e = 0; e < 256; e++) begin
      for (int k = 0; k < 27; k++) begin
        if (k < 23)       fr = 23'd1 << k;
        else if (k == 23) fr = 23'd0;
        else if (k == 24) fr = 23'h7FFFFF;
        else if (k == 25) fr = 23'h2A5A5A;
        else              fr = 23'h612345;
        for (int d = 0; d < 2; d++) begin
          check_one({1'b0, 8'(e), fr}, d[0]);
          pos_res   = res_o;
          pos_flags = {flag_inv_o, flag_den_o};
          check_one({1'b1, 8'(e), fr}, d[0]);
          if (!(e == 255 && fr != 0)) begin
            check("R1", res_o, pos_res);
            check("R1", {30'b0, flag_inv_o, flag_den_o}, {30'b0, pos_flags});
          end
        end
      end
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    #1_500_000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule